// File: doc/BRIEF.md
# CAN Fault Confinement State Tracker

This block keeps the transmit and receive error counters of a CAN node and works out which fault-confinement state the node is in: error-active, warning, error-passive or bus-off. The bit engine next to it reports error events as single-cycle strobes. It also sends a strobe at each sample point, together with the sampled bus level. Software holds a reset-mode bit. The block shows the counters and the state in one 32-bit status word. It raises a one-cycle event whenever the state moves.

Recovery from bus-off does not start by itself. The block first waits until software clears reset mode. It then counts idle conditions on the bus. An idle condition is a run of eleven recessive samples. After 128 such conditions it clears both counters and returns to error-active. In that same cycle it pulses a release output, which tells the transmit queue it may drain the frames that were aborted.

Bit decoding and error detection are outside this block.

Top module: `can_fault_tracker`

## Requirements
- R1: `status_o` holds the receive counter in bits 7:0, the transmit counter in bits 15:8, warning in bit 17, error-passive in bit 18 and bus-off in bit 19. Bit 16 and bits 31:20 always read zero.
- R2: Each `rx_err_i` strobe adds 1 to the receive counter, which saturates at 255. Each `tx_err_i` strobe adds 8 to the transmit counter. Both strobes may be applied in the same cycle.
- R3: Bit 17 is set when either counter is 96 or more, as long as neither error-passive nor bus-off applies.
- R4: Bit 18 is set when either counter is 128 or more, as long as bus-off does not apply.
- R5: Bus-off (bit 19) is entered when the transmit counter would exceed 255. While bus-off holds, bits 15:8 read 255. At most one of bits 19:17 is set at any time, with priority bus-off, then error-passive, then warning.
- R6: While bus-off holds, error strobes are ignored and both counters stay frozen.
- R7: While `reset_mode_i` is 1, error strobes are ignored and bus samples do not advance bus-off recovery. Entering reset mode discards any idle conditions already counted.
- R8: With reset mode clear and bus-off held, each `sample_i` with `bus_bit_i`=1 (recessive) extends the current run, and a sample with `bus_bit_i`=0 (dominant) clears it. Eleven recessive samples in a row make one idle condition. The 128th idle condition ends recovery.
- R9: When recovery ends, both counters become 0 and the state becomes error-active (bits 19:17 = 000).
- R10: `state_chg_o` is high for exactly the cycles in which bits 19:17 differ from their value in the previous cycle.
- R11: `tx_release_o` pulses for one cycle only in the cycle in which bus-off recovery has completed.
- R12: After `rst_n` is asserted, `status_o` is 0, and both `state_chg_o` and `tx_release_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reset_mode_i | input | 1 | Software reset-mode bit; 1 holds the node offline |
| tx_err_i | input | 1 | Transmit error strobe |
| rx_err_i | input | 1 | Receive error strobe |
| sample_i | input | 1 | Sample-point strobe |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| status_o | output | 32 | Counters and state flags |
| state_chg_o | output | 1 | State-change event |
| tx_release_o | output | 1 | Queue may drain after bus-off recovery |

## Verification
Every result appears one clock edge after the stimulus that causes it. A strobe seen at a rising edge changes the counters and flags in the cycle that follows. The state-change and release pulses appear in that same cycle and last for that one cycle only. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each reading falls exactly in the cycle where the result is due. For recovery, the bench first reads the output one sample short of the 1408 recessive samples, where bus-off must still hold. It then reads it again on the completing sample.

// File: rtl/can_fault_tracker.sv
module can_fault_tracker #(
  parameter int CNT_W       = 8,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 128,
  parameter int TX_STEP     = 8,
  parameter int RX_STEP     = 1,
  parameter int IDLE_BITS   = 11,
  parameter int IDLE_COUNT  = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reset_mode_i,
  input  logic        tx_err_i,
  input  logic        rx_err_i,
  input  logic        sample_i,
  input  logic        bus_bit_i,
  output logic [31:0] status_o,
  output logic        state_chg_o,
  output logic        tx_release_o
);
  localparam int TW = CNT_W + 1;
  localparam int RW = $clog2(IDLE_BITS);
  localparam int IW = $clog2(IDLE_COUNT);
  localparam logic [TW-1:0] TX_INC   = TX_STEP;
  localparam logic [TW-1:0] RX_INC   = RX_STEP;
  localparam logic [TW-1:0] WARN_V   = WARN_LVL;
  localparam logic [TW-1:0] PASS_V   = PASSIVE_LVL;
  localparam logic [RW-1:0] RUN_LAST = RW'(IDLE_BITS - 1);
  localparam logic [IW-1:0] IDL_LAST = IW'(IDLE_COUNT - 1);

  logic [CNT_W-1:0] rx_q;
  logic [TW-1:0]    tx_q;
  logic [RW-1:0]    run_q;
  logic [IW-1:0]    idle_q;
  logic [2:0]       flags, prev_q;
  logic             release_q;

  logic          bus_off, passive, warn, can_count, counting, run_done, recover_done;
  logic [TW-1:0] rx_wide, rx_sum, tx_sum;
  logic [CNT_W-1:0] rx_sat;

  assign rx_wide  = {1'b0, rx_q};
  assign bus_off  = tx_q[CNT_W];
  assign passive  = !bus_off && (tx_q >= PASS_V || rx_wide >= PASS_V);
  assign warn     = !bus_off && !passive && (tx_q >= WARN_V || rx_wide >= WARN_V);
  assign flags    = {bus_off, passive, warn};

  assign can_count    = !bus_off && !reset_mode_i;
  assign counting     = bus_off && !reset_mode_i && sample_i;
  assign run_done     = counting && bus_bit_i && (run_q == RUN_LAST);
  assign recover_done = run_done && (idle_q == IDL_LAST);

  assign tx_sum = tx_q + TX_INC;
  assign rx_sum = rx_wide + RX_INC;
  assign rx_sat = rx_sum[CNT_W] ? '1 : rx_sum[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q      <= '0;
      tx_q      <= '0;
      run_q     <= '0;
      idle_q    <= '0;
      prev_q    <= '0;
      release_q <= 1'b0;
    end else begin
      prev_q    <= flags;
      release_q <= recover_done;
      if (recover_done) begin
        rx_q   <= '0;
        tx_q   <= '0;
        run_q  <= '0;
        idle_q <= '0;
      end else begin
        if (can_count && tx_err_i) tx_q <= tx_sum;
        if (can_count && rx_err_i) rx_q <= rx_sat;
        if (!bus_off || reset_mode_i) begin
          run_q  <= '0;
          idle_q <= '0;
        end else if (counting) begin
          if (!bus_bit_i) run_q <= '0;
          else if (run_done) begin
            run_q  <= '0;
            idle_q <= idle_q + 1'b1;
          end else run_q <= run_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    status_o        = '0;
    status_o[7:0]   = 8'(rx_q);
    status_o[15:8]  = bus_off ? 8'hFF : 8'(tx_q[CNT_W-1:0]);
    status_o[19:17] = flags;
  end

  assign state_chg_o  = flags != prev_q;
  assign tx_release_o = release_q;
endmodule

module can_fault_tracker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reset_mode_i,
  input logic        tx_err_i,
  input logic        rx_err_i,
  input logic        sample_i,
  input logic        bus_bit_i,
  input logic [31:0] status_o,
  input logic        state_chg_o,
  input logic        tx_release_o
);
  assert_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31:20] == '0 && !status_o[16]);

  assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_o[19:17]));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[19] && (tx_err_i || rx_err_i) && !sample_i |=> $stable(status_o[15:0]));

  assert_resetmode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode_i |=> $stable(status_o[19:0]));

  assert_recover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[19]) |-> status_o[19:0] == '0);

  assert_chg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg_o == (status_o[19:17] != $past(status_o[19:17])));

  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_release_o |-> $fell(status_o[19]));
endmodule

bind can_fault_tracker can_fault_tracker_chk u_chk (.*);

// File: tb/can_fault_tracker_bench.sv
module can_fault_tracker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_mode_i = 1'b0, tx_err_i = 1'b0, rx_err_i = 1'b0, sample_i = 1'b0, bus_bit_i = 1'b1;
  logic [31:0] status_o;
  logic state_chg_o, tx_release_o;

  int tests = 0, fails = 0, chg_cnt = 0, rel_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_fault_tracker u_can_fault_tracker (.*);

  // {count, tx, rx, exp_rx, exp_tx, exp_flags{bus_off,passive,warn}}
  localparam logic [28:0] VEC [11] = '{
    {8'd95,  1'b0, 1'b1, 8'd95,  8'd0,   3'b000},
    {8'd1,   1'b0, 1'b1, 8'd96,  8'd0,   3'b001},
    {8'd12,  1'b1, 1'b0, 8'd96,  8'd96,  3'b001},
    {8'd31,  1'b0, 1'b1, 8'd127, 8'd96,  3'b001},
    {8'd1,   1'b0, 1'b1, 8'd128, 8'd96,  3'b010},
    {8'd4,   1'b1, 1'b0, 8'd128, 8'd128, 3'b010},
    {8'd127, 1'b0, 1'b1, 8'd255, 8'd128, 3'b010},
    {8'd5,   1'b0, 1'b1, 8'd255, 8'd128, 3'b010},
    {8'd15,  1'b1, 1'b0, 8'd255, 8'd248, 3'b010},
    {8'd1,   1'b1, 1'b0, 8'd255, 8'd255, 3'b100},
    {8'd3,   1'b1, 1'b1, 8'd255, 8'd255, 3'b100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic r, input logic s, input logic b);
    tx_err_i = t; rx_err_i = r; sample_i = s; bus_bit_i = b;
    @(negedge clk);
    chg_cnt += int'(state_chg_o);
    rel_cnt += int'(tx_release_o);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 status", status_o, 32'h0);
    chk("R12 events", {30'b0, state_chg_o, tx_release_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      for (int k = 0; k < int'(VEC[i][28:21]); k++) step(VEC[i][20], VEC[i][19], 1'b0, 1'b1);
      chk(i == 10 ? "R6 frozen counters" : "R2 counters", {16'b0, status_o[15:0]},
          {16'b0, VEC[i][10:3], VEC[i][18:11]});
      chk("R3 R4 R5 flags", {29'b0, status_o[19:17]}, {29'b0, VEC[i][2:0]});
      chk("R1 spare bits", status_o & 32'hFFF1_0000, 32'h0);
    end
    chk("R10 change count", chg_cnt, 3);
    step(1'b0, 1'b0, 1'b0, 1'b1);

    reset_mode_i = 1'b1;
    chg_cnt = 0;
    for (int k = 0; k < 1500; k++) step(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R7 recovery held in reset mode", {31'b0, status_o[19]}, 32'h1);

    reset_mode_i = 1'b0;
    for (int k = 0; k < 10; k++) step(1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 1407; k++) step(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 still bus-off one sample early", {31'b0, status_o[19]}, 32'h1);
    chk("R11 no early release", rel_cnt, 0);
    chk("R10 no change during recovery", chg_cnt, 0);

    step(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R9 recovered status", status_o, 32'h0);
    chk("R10 R11 events on recovery", {30'b0, state_chg_o, tx_release_o}, 32'h3);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 R11 single-cycle pulses", {30'b0, state_chg_o, tx_release_o}, 32'h0);

    reset_mode_i = 1'b1;
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R7 strobes ignored in reset mode", status_o, 32'h0);
    reset_mode_i = 1'b0;
    step(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R2 tx step", status_o, 32'h0000_0800);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R2 rx step", status_o, 32'h0000_0801);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule